// File: doc/BRIEF.md
# Memory Bus Address Router

This block sits between a 16-bit processor and its memories. A single byte address carried on one bus is split into three fixed windows. The lowest quarter reaches a read-only program store, the second quarter reaches a small set of I/O registers, and the upper half reaches a read-write data RAM. The router decides which window an access falls in. It sends write enables, byte-lane masks and lane-aligned write data only to the RAM, and it returns the selected target's read data to the processor as a full word or as a zero-extended byte.

The program store and the data RAM sit outside the block. Both are word-organised and return read data combinationally. The router gives each of them a word index taken from the byte address with bit 0 dropped. Words are little-endian: the byte at the even address is bits 7:0. The I/O window holds a free-running cycle counter, a transmit byte register with a one-cycle strobe, and a view of an incoming receive byte with its valid flag. The router raises a pop pulse when the processor reads that receive byte.

Top module: `mem_router`

## Requirements
- R1: Addresses with bits 15:14 equal to 00 select the program store. Read data comes from `rom_rdata`, and `rom_addr` carries address bits 13:1.
- R2: Addresses with bit 15 set select the RAM, and `ram_addr` carries address bits 14:1. A word store drives `ram_we` with `ram_be` = 11 and the full write word, and a word load returns `ram_rdata`.
- R3: A store whose address lies in the program window has no effect. `ram_we` stays low, no transmit strobe follows, and RAM contents are unchanged.
- R4: A byte load returns the selected byte zero-extended to 16 bits. Address bit 0 = 0 picks bits 7:0 and bit 0 = 1 picks bits 15:8. This applies in every window.
- R5: A byte store to RAM takes the byte from `cpu_wdata[7:0]` and places it on the lane chosen by address bit 0. It asserts only that lane's `ram_be` bit (bit 0 for the low lane, bit 1 for the high lane), and the other byte of the word keeps its value.
- R6: The cycle counter reads at I/O byte offset 0 (address 0x4000), zero-extended. It is 0 in reset, increments by one on every clock edge, wraps at its width, and ignores stores.
- R7: A store to I/O offset 2 (address 0x4002), word or byte, loads `cpu_wdata[7:0]` into `tx_data`. `tx_valid` is high for exactly the one cycle after the store edge, and `tx_data` then holds. A load from this location returns `tx_data` zero-extended.
- R8: A load from I/O offset 4 (address 0x4004) returns `rx_valid` in bit 8 and `rx_data` in bits 7:0. `rx_pop` is high during that load only while `cpu_rd` and `rx_valid` are both high.
- R9: Loads from any other I/O word return zero. Word accesses ignore address bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | Byte address of the access |
| cpu_rd | input | 1 | Load in progress |
| cpu_wr | input | 1 | Store in progress |
| cpu_byte | input | 1 | 1 = byte access, 0 = word access |
| cpu_wdata | input | 16 | Store data (byte stores use bits 7:0) |
| cpu_rdata | output | 16 | Load data returned to the processor |
| rom_addr | output | 13 | Program store word index |
| rom_rdata | input | 16 | Program store read word |
| ram_addr | output | 14 | RAM word index |
| ram_we | output | 1 | RAM write enable |
| ram_be | output | 2 | RAM byte-lane write mask |
| ram_wdata | output | 16 | RAM write word, lane aligned |
| ram_rdata | input | 16 | RAM read word |
| tx_data | output | 8 | Last transmitted byte |
| tx_valid | output | 1 | One-cycle transmit strobe |
| rx_data | input | 8 | Incoming receive byte |
| rx_valid | input | 1 | Receive byte available |
| rx_pop | output | 1 | Receive byte consumed by a load |

## Verification
The bench keeps the 16-bit address width and builds the router with an 8-bit cycle counter (CNT_W = 8). With that width the counter wraps within a few hundred cycles, so the bench can observe the wrap to zero directly rather than waiting 65536 cycles. The RAM model keeps only the low six bits of the word index, so stores reach addresses at both ends of the RAM window. The program store is a computed function of its index, so checks at the first and last program words need no stored table.

// File: rtl/mem_router_pkg.sv
package mem_router_pkg;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        RGN_ROM = 2'd0,
        RGN_IO  = 2'd1,
        RGN_RAM = 2'd2
    } region_e;
endpackage

// File: rtl/mem_router_decode.sv
module mem_router_decode
    import mem_router_pkg::*;
(
    input  logic [1:0] addr_hi,
    output region_e    region
);
    // Bit 15 wins: the whole upper half is RAM; bit 14 then splits I/O from program store
    always_comb begin
        if (addr_hi[1])      region = RGN_RAM;
        else if (addr_hi[0]) region = RGN_IO;
        else                 region = RGN_ROM;
    end
endmodule

// File: rtl/mem_router_lane.sv
module mem_router_lane
    import mem_router_pkg::*;
(
    input  logic              byte_mode,
    input  logic              lane_hi,
    input  logic [DATA_W-1:0] rd_word,
    input  logic [DATA_W-1:0] wr_src,
    output logic [DATA_W-1:0] rd_out,
    output logic [DATA_W-1:0] wr_word,
    output logic [1:0]        wr_be
);
    always_comb begin
        rd_out = rd_word;
        if (byte_mode) begin
            rd_out = '0;
            rd_out[BYTE_W-1:0] = lane_hi ? rd_word[DATA_W-1:BYTE_W] : rd_word[BYTE_W-1:0];
        end
    end

    always_comb begin
        if (byte_mode) begin
            wr_word = {wr_src[BYTE_W-1:0], wr_src[BYTE_W-1:0]};
            wr_be   = lane_hi ? 2'b10 : 2'b01;
        end else begin
            wr_word = wr_src;
            wr_be   = 2'b11;
        end
    end
endmodule

// File: rtl/mem_router_io.sv
module mem_router_io
    import mem_router_pkg::*;
#(
    parameter int IDX_W = 13,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_sel,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [IDX_W-1:0]  io_idx,
    input  logic [BYTE_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic              rx_pop
);
    localparam logic [IDX_W-1:0] IDX_CNT = IDX_W'(0);
    localparam logic [IDX_W-1:0] IDX_TX  = IDX_W'(1);
    localparam logic [IDX_W-1:0] IDX_RX  = IDX_W'(2);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] tx_data;
        logic              tx_valid;
    } io_state_t;

    io_state_t st_d, st_q;
    logic      wr_tx;

    assign wr_tx = io_sel && io_wr && (io_idx == IDX_TX);

    always_comb begin
        st_d          = st_q;
        st_d.cnt      = st_q.cnt + 1'b1;
        st_d.tx_valid = wr_tx;
        if (wr_tx) st_d.tx_data = io_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        io_rdata = '0;
        unique case (io_idx)
            IDX_CNT: io_rdata[CNT_W-1:0]  = st_q.cnt;
            IDX_TX:  io_rdata[BYTE_W-1:0] = st_q.tx_data;
            IDX_RX:  io_rdata[BYTE_W:0]   = {rx_valid, rx_data};
            default: io_rdata = '0;
        endcase
    end

    assign tx_data  = st_q.tx_data;
    assign tx_valid = st_q.tx_valid;
    assign rx_pop   = io_sel && io_rd && (io_idx == IDX_RX) && rx_valid;

    // R6: counter advances by one on every edge out of reset
    assert_cnt_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> st_q.cnt == $past(st_q.cnt) + 1'b1);
    // R7: strobe only follows a store to the transmit word
    assert_tx_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(io_sel && io_wr && io_idx == IDX_TX));
    // R7: strobed byte is the stored byte
    assert_tx_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> tx_data == $past(io_wdata));
    // R7: held byte changes only with a strobe
    assert_tx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_valid |-> $stable(tx_data));
endmodule

// File: rtl/mem_router.sv
module mem_router
    import mem_router_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic                cpu_rd,
    input  logic                cpu_wr,
    input  logic                cpu_byte,
    input  logic [15:0]         cpu_wdata,
    output logic [15:0]         cpu_rdata,
    output logic [ADDR_W-4:0]   rom_addr,
    input  logic [15:0]         rom_rdata,
    output logic [ADDR_W-3:0]   ram_addr,
    output logic                ram_we,
    output logic [1:0]          ram_be,
    output logic [15:0]         ram_wdata,
    input  logic [15:0]         ram_rdata,
    output logic [7:0]          tx_data,
    output logic                tx_valid,
    input  logic [7:0]          rx_data,
    input  logic                rx_valid,
    output logic                rx_pop
);
    localparam int SMALL_IDX_W = ADDR_W - 3;

    region_e           region;
    logic [DATA_W-1:0] io_rdata;
    logic [DATA_W-1:0] word_rd;
    logic [1:0]        lane_be;

    mem_router_decode u_decode (
        .addr_hi (cpu_addr[ADDR_W-1:ADDR_W-2]),
        .region  (region)
    );

    mem_router_io #(.IDX_W(SMALL_IDX_W), .CNT_W(CNT_W)) u_io (
        .clk      (clk),
        .rst_n    (rst_n),
        .io_sel   (region == RGN_IO),
        .io_wr    (cpu_wr),
        .io_rd    (cpu_rd),
        .io_idx   (cpu_addr[ADDR_W-3:1]),
        .io_wdata (cpu_wdata[BYTE_W-1:0]),
        .io_rdata (io_rdata),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .rx_pop   (rx_pop)
    );

    always_comb begin
        unique case (region)
            RGN_ROM: word_rd = rom_rdata;
            RGN_IO:  word_rd = io_rdata;
            default: word_rd = ram_rdata;
        endcase
    end

    mem_router_lane u_lane (
        .byte_mode (cpu_byte),
        .lane_hi   (cpu_addr[0]),
        .rd_word   (word_rd),
        .wr_src    (cpu_wdata),
        .rd_out    (cpu_rdata),
        .wr_word   (ram_wdata),
        .wr_be     (lane_be)
    );

    assign rom_addr = cpu_addr[ADDR_W-3:1];
    assign ram_addr = cpu_addr[ADDR_W-2:1];
    assign ram_we   = cpu_wr && (region == RGN_RAM);
    assign ram_be   = lane_be;

    // R1: exactly one target decoded
    assert_one_region_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({region == RGN_ROM, region == RGN_IO, region == RGN_RAM}));
    // R3: program window stores never reach RAM
    assert_rom_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[ADDR_W-1:ADDR_W-2] == 2'b00) |-> !ram_we);
    // R5: byte stores touch one lane, word stores both
    assert_byte_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $countones(ram_be) == (cpu_byte ? 1 : 2));
    // R4: byte loads never carry an upper byte
    assert_byte_zext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_byte |-> cpu_rdata[15:8] == 8'h00);
endmodule

// File: tb/mem_router_test.sv
module mem_router_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0, cpu_byte = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic [12:0] rom_addr;
    logic [15:0] rom_rdata;
    logic [13:0] ram_addr;
    logic        ram_we;
    logic [1:0]  ram_be;
    logic [15:0] ram_wdata, ram_rdata;
    logic [7:0]  tx_data, rx_data = '0;
    logic        tx_valid, rx_valid = 1'b0, rx_pop;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mem_router #(.ADDR_W(16), .CNT_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_byte(cpu_byte), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .rom_addr(rom_addr), .rom_rdata(rom_rdata),
        .ram_addr(ram_addr), .ram_we(ram_we), .ram_be(ram_be),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .tx_data(tx_data),
        .tx_valid(tx_valid), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_pop(rx_pop)
    );

    function automatic logic [15:0] rom_val(logic [12:0] idx);
        return (16'(idx) * 16'd37) ^ 16'h5A00;
    endfunction
    assign rom_rdata = rom_val(rom_addr);

    logic [15:0] mem [64];
    initial for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
    always @(posedge clk) if (ram_we) begin
        if (ram_be[0]) mem[ram_addr[5:0]][7:0]  <= ram_wdata[7:0];
        if (ram_be[1]) mem[ram_addr[5:0]][15:8] <= ram_wdata[15:8];
    end
    assign ram_rdata = mem[ram_addr[5:0]];

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(logic [15:0] a, logic b, output logic [15:0] v);
        @(negedge clk);
        cpu_addr = a; cpu_byte = b; cpu_rd = 1'b1; cpu_wr = 1'b0;
        #1 v = cpu_rdata;
    endtask

    task automatic wr(logic [15:0] a, logic b, logic [15:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_byte = b; cpu_wdata = d; cpu_rd = 1'b0; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        cpu_addr = 16'h4000; cpu_rd = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1 v = cpu_rdata;
        check("R6 counter at reset", v, 16'h0000);
        check("R7 tx_valid at reset", 16'(tx_valid), 16'h0000);
        check("R7 tx_data at reset", 16'(tx_data), 16'h0000);
    endtask

    task automatic t_rom;
        logic [15:0] v;
        rd(16'h0000, 1'b0, v); check("R1 rom first word", v, rom_val(13'h0000));
        rd(16'h0002, 1'b0, v); check("R1 rom word 1", v, rom_val(13'h0001));
        check("R1 rom_addr index", 16'(rom_addr), 16'h0001);
        rd(16'h3FFE, 1'b0, v); check("R1 rom last word", v, rom_val(13'h1FFF));
    endtask

    task automatic t_ram;
        logic [15:0] v;
        @(negedge clk);
        cpu_addr = 16'h8010; cpu_byte = 1'b0; cpu_wdata = 16'h1234; cpu_wr = 1'b1;
        #1 check("R2 ram_we on word store", 16'(ram_we), 16'h0001);
        check("R2 ram_be on word store", 16'(ram_be), 16'h0003);
        check("R2 ram_addr index", 16'(ram_addr), 16'h0008);
        @(negedge clk); cpu_wr = 1'b0;
        rd(16'h8010, 1'b0, v); check("R2 ram word readback", v, 16'h1234);
        rd(16'h8011, 1'b0, v); check("R9 word load ignores bit0", v, 16'h1234);
        wr(16'hFFFE, 1'b0, 16'hBEEF);
        rd(16'hFFFE, 1'b0, v); check("R2 ram top word", v, 16'hBEEF);
    endtask

    task automatic t_rom_write;
        logic [15:0] v;
        @(negedge clk);
        cpu_addr = 16'h0010; cpu_byte = 1'b0; cpu_wdata = 16'hDEAD; cpu_wr = 1'b1;
        #1 check("R3 no ram_we on rom store", 16'(ram_we), 16'h0000);
        @(negedge clk); cpu_wr = 1'b0;
        #1 check("R3 no tx strobe after rom store", 16'(tx_valid), 16'h0000);
        rd(16'h8010, 1'b0, v); check("R3 ram unchanged", v, 16'h1234);
        rd(16'h0010, 1'b0, v); check("R3 rom still rom", v, rom_val(13'h0008));
    endtask

    task automatic t_byte_load;
        logic [15:0] v, r;
        rd(16'h8010, 1'b1, v); check("R4 byte load low lane", v, 16'h0034);
        rd(16'h8011, 1'b1, v); check("R4 byte load high lane", v, 16'h0012);
        r = rom_val(13'h0001);
        rd(16'h0003, 1'b1, v); check("R4 byte load rom high", v, {8'h00, r[15:8]});
    endtask

    task automatic t_byte_store;
        logic [15:0] v;
        @(negedge clk);
        cpu_addr = 16'h8011; cpu_byte = 1'b1; cpu_wdata = 16'hFFAB; cpu_wr = 1'b1;
        #1 check("R5 high lane mask", 16'(ram_be), 16'h0002);
        @(negedge clk); cpu_wr = 1'b0;
        rd(16'h8010, 1'b0, v); check("R5 high byte store", v, 16'hAB34);
        wr(16'h8010, 1'b1, 16'h00CD);
        rd(16'h8010, 1'b0, v); check("R5 low byte store", v, 16'hABCD);
    endtask

    task automatic t_counter;
        logic [15:0] v1, v2;
        logic seen;
        rd(16'h4000, 1'b0, v1);
        repeat (5) @(negedge clk);
        #1 v2 = cpu_rdata;
        check("R6 counter steps", v2, 16'((v1 + 16'd5) & 16'h00FF));
        @(negedge clk);
        cpu_wr = 1'b1; cpu_wdata = 16'h0000;
        #1 v1 = cpu_rdata;
        @(negedge clk); cpu_wr = 1'b0;
        #1 check("R6 counter ignores store", cpu_rdata, 16'((v1 + 16'd1) & 16'h00FF));
        seen = 1'b0;
        for (int i = 0; i < 300 && !seen; i++) begin
            @(negedge clk);
            #1 if (cpu_rdata == 16'h00FF) begin
                seen = 1'b1;
                @(negedge clk);
                #1 check("R6 counter wraps", cpu_rdata, 16'h0000);
            end
        end
        check("R6 wrap point reached", 16'(seen), 16'h0001);
    endtask

    task automatic t_tx;
        logic [15:0] v;
        @(negedge clk);
        cpu_addr = 16'h4002; cpu_byte = 1'b0; cpu_wdata = 16'h12C3; cpu_wr = 1'b1;
        #1 check("R7 no strobe before edge", 16'(tx_valid), 16'h0000);
        @(negedge clk); cpu_wr = 1'b0;
        #1 check("R7 strobe after store", 16'(tx_valid), 16'h0001);
        check("R7 captured byte", 16'(tx_data), 16'h00C3);
        @(negedge clk);
        #1 check("R7 strobe one cycle", 16'(tx_valid), 16'h0000);
        check("R7 byte held", 16'(tx_data), 16'h00C3);
        rd(16'h4002, 1'b0, v); check("R7 tx readback", v, 16'h00C3);
        wr(16'h4002, 1'b1, 16'h0077);
        check("R7 byte store to tx", 16'(tx_data), 16'h0077);
    endtask

    task automatic t_rx;
        logic [15:0] v;
        rx_data = 8'h5E; rx_valid = 1'b1;
        rd(16'h4004, 1'b0, v); check("R8 rx with valid", v, 16'h015E);
        check("R8 pop on load", 16'(rx_pop), 16'h0001);
        rx_valid = 1'b0;
        #1 check("R8 rx without valid", cpu_rdata, 16'h005E);
        check("R8 no pop without valid", 16'(rx_pop), 16'h0000);
        rx_valid = 1'b1; cpu_rd = 1'b0;
        #1 check("R8 no pop without load", 16'(rx_pop), 16'h0000);
        rx_valid = 1'b0;
    endtask

    task automatic t_io_other;
        logic [15:0] v;
        rd(16'h4006, 1'b0, v); check("R9 unused io word", v, 16'h0000);
        rd(16'h7FFE, 1'b0, v); check("R9 top io word", v, 16'h0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_rom();
        t_ram();
        t_rom_write();
        t_byte_load();
        t_byte_store();
        t_counter();
        t_tx();
        t_rx();
        t_io_other();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule